// File: doc/BRIEF.md
# Delta-Panel Horizontal Scan Timing Generator

This block produces the horizontal drive waveforms for a colour TFT panel whose dots sit in a delta pattern. The panel has its own horizontal shift register and samples the red, green and blue video together, three dots per shift-clock pulse. The block runs on the dot-rate clock. On each line-sync pulse it starts one line sequence with four steps. First comes an optional uniformity clear pulse. Then a fixed gap and a programmable delay follow. Last come the start pulse and a burst of two complementary shift clocks. Every count is in dot-clock cycles.

Neighbouring rows of the delta pattern are offset by one and a half dots. For that reason, odd lines of a frame start half a shift-clock period later than even lines. The block also drives a polarity flag for the video path, which inverts on every line because the panel needs line-inverted drive. It also outputs a scan-direction level. For reverse scanning, the two shift clocks are exchanged so that the image stays centred. The direction and the use of the clear pulse are sampled at each line sync. The three timing counts are captured while reset is held.

Top module: `delta_hscan_gen`

## Requirements
- R1: `hck1` and `hck2` are always exact complements. While no line is running and `hdir` is 1, `hck1` is 0.
- R2: Each completed line produces exactly NUM_PULSES rising edges on the leading clock. The leading clock is `hck1` when `hdir` is 1 and `hck2` when it is 0. Each pulse is HALF_PER cycles high followed by HALF_PER cycles low, and the first rise comes HALF_PER cycles after the scan phase begins.
- R3: `hst` is high for 2*HALF_PER cycles. It rises HALF_PER cycles before the first leading-clock rise and falls in the same cycle as the first leading-clock fall.
- R4: On an even line, `hst` rises W+G+D+2 cycles after the clock edge that samples `line_sync`. W, G and D are the captured clear-width, gap and delay counts.
- R5: On an odd line, the `hst` rise comes HALF_PER cycles later than on an even line.
- R6: `vpol` inverts at every sampled `line_sync`. It is forced to 0 when `frame_sync` is high together with `line_sync`, so the flag equals the parity of the line within its frame.
- R7: `hdir` takes the value of `dir_ltr` at each sampled `line_sync` and holds it otherwise. When `hdir` is 0, the `hck1` and `hck2` waveforms are exchanged.
- R8: When `clr_en` was 1 at the line sync and W>0, `hclr` is high for W cycles starting 1 cycle after the sync edge. When `clr_en` was 0, or W=0, `hclr` stays low for the whole line.
- R9: `hclr` falls G+1 cycles before the scan delay begins, so it is low before `hst` rises, with the gap equal to G+1+D (plus HALF_PER on odd lines).
- R10: The W, G and D counts are taken from the configuration inputs only while `rst_n` is low. Changes to those inputs after reset have no effect.
- R11: A `line_sync` that arrives while a line is in progress abandons that line and restarts the sequence from the clear step.
- R12: During reset, `hst`, `hclr` and `vpol` are 0, `hdir` is 1, `hck1` is 0 and `hck2` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot-rate clock |
| rst_n | input | 1 | Active-low reset; configuration is captured while low |
| line_sync | input | 1 | One-cycle pulse that starts a line |
| frame_sync | input | 1 | High with `line_sync` on the first line of a frame |
| dir_ltr | input | 1 | 1 = left-to-right scan, 0 = right-to-left |
| clr_en | input | 1 | 1 = generate the clear pulse on this line |
| cfg_start_dly | input | CFG_W | Delay count D before the scan phase |
| cfg_clr_width | input | CFG_W | Clear pulse width W |
| cfg_clr_gap | input | CFG_W | Gap count G (the actual gap is G+1) |
| hst | output | 1 | Shift-register start pulse |
| hck1 | output | 1 | Shift clock one |
| hck2 | output | 1 | Shift clock two, the complement of `hck1` |
| hclr | output | 1 | Uniformity clear pulse |
| hdir | output | 1 | Scan-direction level to the panel |
| vpol | output | 1 | Video polarity flag for the current line |

## Verification
The bench aims at the line-to-line offset. It checks that the start edge lands exactly HALF_PER cycles later on odd lines, and that this lateness resets at a frame sync. A design that keyed the offset to the wrong parity, or never reset it, would put every start edge half a period off. The bench runs reverse-direction lines, where a design that inverted only one clock would break the complement or send the wrong clock to the panel. It also runs a restart in the middle of the burst, where a design that did not reload its counters would emit extra pulses. Finally, it uses a zero clear width and zero gap after a second reset. That is where an off-by-one in skipping empty steps would let `hclr` overlap `hst`, or shift the start by a cycle.

// File: rtl/delta_hscan_pkg.sv
package delta_hscan_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_CLR  = 3'd1,
      PH_GAP  = 3'd2,
      PH_DLY  = 3'd3,
      PH_RUN  = 3'd4
   } hphase_e;

endpackage

// File: rtl/delta_hscan_line.sv
module delta_hscan_line (
   input  logic clk,
   input  logic rst_n,
   input  logic line_sync,
   input  logic frame_sync,
   input  logic dir_ltr,
   input  logic clr_en,
   output logic line_odd,
   output logic dir_q,
   output logic clr_use
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_odd <= 1'b0;
         dir_q    <= 1'b1;
         clr_use  <= 1'b0;
      end else if (line_sync) begin
         line_odd <= frame_sync ? 1'b0 : ~line_odd;
         dir_q    <= dir_ltr;
         clr_use  <= clr_en;
      end
   end

   p_pol_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_sync && !frame_sync) |=> (line_odd != $past(line_odd)));

   p_pol_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_sync && frame_sync) |=> !line_odd);

   p_dir_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !line_sync |=> $stable(dir_q));

endmodule

// File: rtl/delta_hscan_seq.sv
module delta_hscan_seq
   import delta_hscan_pkg::*;
#(
   parameter int CFG_W      = 8,
   parameter int HALF_PER   = 2,
   parameter int NUM_PULSES = 271,
   parameter int CNT_W      = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_sync,
   input  logic             line_odd,
   input  logic [CFG_W-1:0] cfg_w,
   input  logic [CFG_W-1:0] cfg_g,
   input  logic [CFG_W-1:0] cfg_d,
   output hphase_e          phase,
   output logic [CNT_W-1:0] cnt
);

   localparam int RUN_LEN = (2 * NUM_PULSES + 1) * HALF_PER;
   localparam logic [CNT_W-1:0] RUN_LEN_C = CNT_W'(RUN_LEN);
   localparam logic [CNT_W-1:0] HALF_C    = CNT_W'(HALF_PER);

   logic [CNT_W-1:0] len_clr, len_gap, len_dly, len_now;
   logic             last;
   hphase_e          ph_after;

   always_comb begin
      len_clr = CNT_W'(cfg_w);
      len_gap = CNT_W'(cfg_g) + CNT_W'(1);
      len_dly = CNT_W'(cfg_d) + (line_odd ? HALF_C : '0);
      unique case (phase)
         PH_CLR:  len_now = len_clr;
         PH_GAP:  len_now = len_gap;
         PH_DLY:  len_now = len_dly;
         PH_RUN:  len_now = RUN_LEN_C;
         default: len_now = '0;
      endcase
      last = (cnt == len_now - CNT_W'(1));
      unique case (phase)
         PH_CLR:  ph_after = PH_GAP;
         PH_GAP:  ph_after = (len_dly != '0) ? PH_DLY : PH_RUN;
         PH_DLY:  ph_after = PH_RUN;
         default: ph_after = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else if (line_sync) begin
         phase <= (cfg_w != '0) ? PH_CLR : PH_GAP;
         cnt   <= '0;
      end else if (phase != PH_IDLE) begin
         if (last) begin
            phase <= ph_after;
            cnt   <= '0;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

   p_run_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RUN && cnt == RUN_LEN_C - CNT_W'(1) && !line_sync) |=> (phase == PH_IDLE));

   p_clr_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_sync && cfg_w != '0) |=> (phase == PH_CLR && cnt == '0));

   p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (line_sync && phase == PH_RUN) |=> (phase != PH_RUN));

endmodule

// File: rtl/delta_hscan_drv.sv
module delta_hscan_drv
   import delta_hscan_pkg::*;
#(
   parameter int HALF_PER = 2,
   parameter int CNT_W    = 12,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  hphase_e          phase,
   input  logic [CNT_W-1:0] cnt,
   input  logic             dir_q,
   input  logic             clr_use,
   output logic             hst,
   output logic             hck1,
   output logic             hck2,
   output logic             hclr
);

   localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF_PER);
   localparam logic [CNT_W-1:0] STW_C  = CNT_W'(2 * HALF_PER);

   logic             run, lead;
   logic [CNT_W-1:0] half_idx;
   logic             hst_c, hck1_c, hck2_c, hclr_c;

   always_comb begin
      run      = (phase == PH_RUN);
      half_idx = cnt / HALF_C;
      lead     = run && half_idx[0];
      hst_c    = run && (cnt < STW_C);
      hclr_c   = (phase == PH_CLR) && clr_use;
      hck1_c   = dir_q ? lead : ~lead;
      hck2_c   = dir_q ? ~lead : lead;
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hst  <= 1'b0;
               hck1 <= 1'b0;
               hck2 <= 1'b1;
               hclr <= 1'b0;
            end else begin
               hst  <= hst_c;
               hck1 <= hck1_c;
               hck2 <= hck2_c;
               hclr <= hclr_c;
            end
         end
      end else begin : g_comb
         assign hst  = hst_c;
         assign hck1 = hck1_c;
         assign hck2 = hck2_c;
         assign hclr = hclr_c;
      end
   endgenerate

   p_complement_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hck1 ^ hck2));

   p_clr_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hclr && hst));

endmodule

// File: rtl/delta_hscan_gen.sv
module delta_hscan_gen
   import delta_hscan_pkg::*;
#(
   parameter int CFG_W      = 8,
   parameter int HALF_PER   = 2,
   parameter int NUM_PULSES = 271,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_sync,
   input  logic             frame_sync,
   input  logic             dir_ltr,
   input  logic             clr_en,
   input  logic [CFG_W-1:0] cfg_start_dly,
   input  logic [CFG_W-1:0] cfg_clr_width,
   input  logic [CFG_W-1:0] cfg_clr_gap,
   output logic             hst,
   output logic             hck1,
   output logic             hck2,
   output logic             hclr,
   output logic             hdir,
   output logic             vpol
);

   localparam int RUN_LEN = (2 * NUM_PULSES + 1) * HALF_PER;
   localparam int CFG_MAX = (1 << CFG_W);
   localparam int DLY_MAX = CFG_MAX - 1 + HALF_PER;
   localparam int LEN_A   = (RUN_LEN > DLY_MAX) ? RUN_LEN : DLY_MAX;
   localparam int LEN_MAX = (LEN_A > CFG_MAX) ? LEN_A : CFG_MAX;
   localparam int CNT_W   = $clog2(LEN_MAX + 1);

   initial begin : elab_chk
      assert (HALF_PER >= 1) else $error("HALF_PER must be at least 1");
      assert (NUM_PULSES >= 1) else $error("NUM_PULSES must be at least 1");
      assert (CFG_W >= 1 && CFG_W <= 16) else $error("CFG_W out of range");
   end

   logic [CFG_W-1:0] cfg_w_q, cfg_g_q, cfg_d_q;
   logic             line_odd, dir_q, clr_use;
   hphase_e          phase;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_w_q <= cfg_clr_width;
         cfg_g_q <= cfg_clr_gap;
         cfg_d_q <= cfg_start_dly;
      end
   end

   delta_hscan_line u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_sync  (line_sync),
      .frame_sync (frame_sync),
      .dir_ltr    (dir_ltr),
      .clr_en     (clr_en),
      .line_odd   (line_odd),
      .dir_q      (dir_q),
      .clr_use    (clr_use)
   );

   delta_hscan_seq #(
      .CFG_W      (CFG_W),
      .HALF_PER   (HALF_PER),
      .NUM_PULSES (NUM_PULSES),
      .CNT_W      (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_sync (line_sync),
      .line_odd  (line_odd),
      .cfg_w     (cfg_w_q),
      .cfg_g     (cfg_g_q),
      .cfg_d     (cfg_d_q),
      .phase     (phase),
      .cnt       (cnt)
   );

   delta_hscan_drv #(
      .HALF_PER (HALF_PER),
      .CNT_W    (CNT_W),
      .OUT_REG  (OUT_REG)
   ) u_drv (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase   (phase),
      .cnt     (cnt),
      .dir_q   (dir_q),
      .clr_use (clr_use),
      .hst     (hst),
      .hck1    (hck1),
      .hck2    (hck2),
      .hclr    (hclr)
   );

   assign hdir = dir_q;
   assign vpol = line_odd;

   p_hst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hst) && !$past(line_sync)) |-> $fell(hdir ? hck1 : hck2));

   p_clr_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hst) |-> (!hclr && !$past(hclr)));

endmodule

// File: tb/sim_delta_hscan_gen.sv
module sim_delta_hscan_gen;

   localparam int CW   = 6;
   localparam int HP   = 3;
   localparam int NP   = 6;
   localparam int RUNL = (2 * NP + 1) * HP;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_sync = 1'b0, frame_sync = 1'b0, dir_ltr = 1'b1, clr_en = 1'b0;
   logic [CW-1:0] in_w, in_g, in_d;
   logic hst, hck1, hck2, hclr, hdir, vpol;

   always #2 clk = ~clk;

   delta_hscan_gen #(.CFG_W(CW), .HALF_PER(HP), .NUM_PULSES(NP), .OUT_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .frame_sync(frame_sync),
      .dir_ltr(dir_ltr), .clr_en(clr_en), .cfg_start_dly(in_d),
      .cfg_clr_width(in_w), .cfg_clr_gap(in_g), .hst(hst), .hck1(hck1),
      .hck2(hck2), .hclr(hclr), .hdir(hdir), .vpol(vpol)
   );

   int errors = 0;
   int checks = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int tsl = -1, m_odd = 0, m_dir = 1, m_clru = 0, mw = 0, mg = 0, md = 0;
   int age = 0, exp_rise = 0, line_total = -10;
   bit exp_hst = 0, exp_hck1 = 0, exp_hck2 = 1, exp_hclr = 0, exp_vpol = 0, exp_hdir = 1;

   function automatic int dly_len(input int o);
      return md + (o != 0 ? HP : 0);
   endfunction

   always @(posedge clk) begin : model
      bit ld;
      int p;
      if (!rst_n) begin
         mw = int'(in_w); mg = int'(in_g); md = int'(in_d);
         tsl = -1; m_odd = 0; m_dir = 1; m_clru = 0; age = 0; line_total = -10;
         exp_hst = 0; exp_hck1 = 0; exp_hck2 = 1; exp_hclr = 0; exp_vpol = 0; exp_hdir = 1;
      end else begin
         ld = 0; exp_hst = 0; exp_hclr = 0;
         if (tsl >= 0) begin
            if (tsl < mw) exp_hclr = (m_clru != 0);
            p = tsl - (mw + mg + 1 + dly_len(m_odd));
            if (p >= 0 && p < RUNL) begin
               exp_hst = (p < 2 * HP);
               ld = ((p / HP) % 2) == 1;
            end
         end
         exp_hck1 = (m_dir != 0) ? ld : !ld;
         exp_hck2 = !exp_hck1;
         if (line_sync) begin
            tsl = 0;
            m_odd = frame_sync ? 0 : (m_odd == 0 ? 1 : 0);
            m_dir = dir_ltr ? 1 : 0;
            m_clru = clr_en ? 1 : 0;
            age = 0;
            exp_rise = mw + mg + 2 + dly_len(m_odd);
            line_total = mw + mg + 1 + dly_len(m_odd) + RUNL;
         end else begin
            age++;
            if (tsl >= 0) begin
               tsl++;
               if (tsl >= line_total) tsl = -1;
            end
         end
         exp_vpol = (m_odd != 0);
         exp_hdir = (m_dir != 0);
      end
   end

   // per-cycle comparison and line measurements
   string rise_tag = "";
   bit prev_hst = 0, prev_hclr = 0, prev_lead = 0;
   int lead_rises = 0, clr_hi = 0, fall_age = -1, rise_age = -1;

   always @(negedge clk) begin : compare
      bit lead;
      if (rst_n) begin
         chk(hst  == exp_hst,  "R3", int'(hst),  int'(exp_hst));
         chk(hck1 == exp_hck1, "R1", int'(hck1), int'(exp_hck1));
         chk(hck2 == exp_hck2, "R7", int'(hck2), int'(exp_hck2));
         chk(hclr == exp_hclr, "R8", int'(hclr), int'(exp_hclr));
         chk(vpol == exp_vpol, "R6", int'(vpol), int'(exp_vpol));
         chk(hdir == exp_hdir, "R7", int'(hdir), int'(exp_hdir));
         lead = hdir ? hck1 : hck2;
         if (age == 1) begin
            lead_rises = 0; clr_hi = 0; fall_age = -1; rise_age = -1;
         end
         if (hclr) clr_hi++;
         if (!hclr && prev_hclr) fall_age = age;
         if (hst && !prev_hst) begin
            rise_age = age;
            chk(age == exp_rise, (rise_tag != "") ? rise_tag : (exp_vpol ? "R5" : "R4"),
                age, exp_rise);
         end
         if (lead && !prev_lead) lead_rises++;
         if (age == line_total + 1) begin
            chk(lead_rises == NP, "R2", lead_rises, NP);
            chk(clr_hi == ((m_clru != 0 && mw > 0) ? mw : 0), "R8", clr_hi,
                (m_clru != 0 && mw > 0) ? mw : 0);
            if (m_clru != 0 && mw > 0)
               chk(rise_age - fall_age == exp_rise - (mw + 1), "R9",
                   rise_age - fall_age, exp_rise - (mw + 1));
         end
         prev_hst = hst; prev_hclr = hclr; prev_lead = lead;
      end
   end

   task automatic send_line(input bit fs, input bit d, input bit ce, input int len);
      @(posedge clk); #1;
      line_sync = 1'b1; frame_sync = fs; dir_ltr = d; clr_en = ce;
      @(posedge clk); #1;
      line_sync = 1'b0; frame_sync = 1'b0;
      repeat (len - 1) @(posedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin : stim
      in_w = 6'd3; in_g = 6'd1; in_d = 6'd4;
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R12: reset levels {hst,hck1,hck2,hclr,vpol,hdir}
      chk({hst, hck1, hck2, hclr, vpol, hdir} == 6'b001001, "R12",
          int'({hst, hck1, hck2, hclr, vpol, hdir}), 9);
      @(posedge clk); #1;
      rst_n = 1'b1;
      // R10: new inputs after reset must not change the timing
      in_w = 6'd7; in_g = 6'd5; in_d = 6'd9;
      rise_tag = "R10";
      send_line(1'b1, 1'b1, 1'b1, 70);
      rise_tag = "";
      repeat (3) send_line(1'b0, 1'b1, 1'b1, 70);
      send_line(1'b1, 1'b1, 1'b1, 70);
      repeat (2) send_line(1'b0, 1'b0, 1'b1, 70);
      send_line(1'b0, 1'b1, 1'b0, 70);
      send_line(1'b0, 1'b1, 1'b1, 20);
      rise_tag = "R11";
      send_line(1'b0, 1'b1, 1'b1, 70);
      rise_tag = "";
      // second configuration: zero clear width, zero gap, zero delay
      @(posedge clk); #1;
      rst_n = 1'b0; in_w = '0; in_g = '0; in_d = '0;
      repeat (3) @(posedge clk); #1;
      rst_n = 1'b1;
      repeat (2) send_line(1'b0, 1'b1, 1'b1, 70);
      send_line(1'b0, 1'b0, 1'b1, 60);
      finish_run();
   end

endmodule